// File: doc/BRIEF.md
# Banked Scratch Memory Conflict Arbiter

This block sits in front of a scratch memory split into sixteen word-wide banks. It takes one request at a time from a group of sixteen lanes. A request holds one word address per lane, an active mask and a read/write flag. Each lane's address is steered to the bank given by its low address bits. Lanes that land in different banks are served together. Lanes that read or write the very same word are served together as one broadcast. Lanes that meet in one bank at different words are spread over successive cycles. A request therefore takes as many cycles as the largest number of different words asked of any one bank.

On every service cycle the block drives each bank's enable and row address, and shows which lanes were served through a per-lane grant mask. A done flag marks the final service cycle. Read data for the granted lanes comes back one cycle later, with a per-lane valid mask. The banks are plain behavioural arrays held inside the block. When several lanes write one word, the data of the highest-numbered of those lanes is stored.

Top module: `scratch_bank_arb`

## Requirements
- R1: A lane's bank is its word address modulo 16 (address bits 3:0), and the row driven to that bank is the address shifted right by 4.
- R2: When every active lane hits a different bank, all of them are granted in the first service cycle and done is asserted in that cycle.
- R3: When all sixteen lanes read one address, they are all granted in a single cycle and the same word is returned to every lane.
- R4: Conflicting lanes are serialized, and a request lasts as many service cycles as the largest count of distinct addresses in one bank: word stride 2 over sixteen lanes takes 2 cycles and word stride 8 takes 8 cycles.
- R5: In each service cycle, each bank serves the address of its lowest-numbered lane that is still pending, and every other pending lane with exactly that address is granted in the same cycle.
- R6: A lane whose mask bit is 0 is never granted. A request with an all-zero mask takes one service cycle, with done asserted and no grant.
- R7: Lanes that write the same address in one request are all granted in one cycle, and the word stored is the data of the highest-numbered of them.
- R8: A request is taken only while the block is idle. A request presented while an earlier one is still in service is ignored, and no service follows once the earlier one is done.
- R9: For a read, each lane granted in cycle N shows rd_valid high in cycle N+1 together with the stored word at its address. Writes never raise rd_valid.
- R10: While and after reset, with no request, grant, bank_en, done and rd_valid are all 0.
- R11: The first service cycle is the cycle after the request is taken, and done is high in exactly one cycle per request: the last service cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; taken when the block is idle |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_mask | input | 16 | Active lanes |
| req_addr | input | 160 | Ten-bit word address per lane; lane n in bits 10n+9:10n |
| req_wdata | input | 512 | Write data per lane; lane n in bits 32n+31:32n |
| bank_en | output | 16 | Bank access enable for this cycle |
| bank_row | output | 96 | Six-bit row per bank; bank b in bits 6b+5:6b |
| grant | output | 16 | Lanes served in this cycle |
| done | output | 1 | Last service cycle of the current request |
| rd_valid | output | 16 | Lanes with read data this cycle |
| rd_data | output | 512 | Read data per lane, laid out like req_wdata |

## Verification
A request sampled at clock edge k is served from the cycle after edge k. Grant, bank enables, bank rows and done are combinational from state and change right after each edge. Read data and rd_valid for a service cycle are due one cycle after that cycle. The bench computes, per request, the schedule of grant masks a bank-by-bank lowest-lane rule gives. It compares grant, bank enables, rows and done at the falling edge of every service cycle, and it compares read data at the falling edge of the following cycle. The cycle in which done was first seen is checked against the cycle count the requirement demands. One further cycle after done is checked to be idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int NUM_LANES = 16;
  parameter int NUM_BANKS = 16;
  parameter int ADDR_W    = 10;
  parameter int DATA_W    = 32;
endpackage

// File: rtl/arb_bank_pick.sv
// Per-bank selector: picks the lowest pending lane aimed at this bank and
// gathers all pending lanes that share its address.
module arb_bank_pick #(
  parameter int NL       = 16,
  parameter int NB       = 16,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int BANK_IDX = 0,
  localparam int BW      = $clog2(NB),
  localparam int ROW_W   = ADDR_W - BW
) (
  input  logic [NL-1:0]        pending,
  input  logic [NL*ADDR_W-1:0] lane_addr,
  input  logic [NL*DATA_W-1:0] lane_wdata,
  output logic                 en,
  output logic [ROW_W-1:0]     row,
  output logic [NL-1:0]        match,
  output logic [DATA_W-1:0]    wdata
);
  localparam int SEL_W = $clog2(NL);
  localparam logic [BW-1:0] BANK_SEL = BW'(BANK_IDX);

  logic [NL-1:0]     hit;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] lead;

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      hit[l] = pending[l] && (lane_addr[l*ADDR_W +: BW] == BANK_SEL);
    end
    sel = '0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (hit[l]) sel = SEL_W'(l);
    end
    lead = lane_addr[sel*ADDR_W +: ADDR_W];
    en   = |hit;
    row  = lead[ADDR_W-1:BW];
    for (int l = 0; l < NL; l++) begin
      match[l] = hit[l] && (lane_addr[l*ADDR_W +: ADDR_W] == lead);
    end
    // ascending scan: the highest matching lane's data is kept
    wdata = '0;
    for (int l = 0; l < NL; l++) begin
      if (match[l]) wdata = lane_wdata[l*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/arb_bank_ram.sv
// One behavioural bank: one access per cycle, registered read.
module arb_bank_ram #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb #(
  parameter int NUM_LANES = arb_pkg::NUM_LANES,
  parameter int NUM_BANKS = arb_pkg::NUM_BANKS,
  parameter int ADDR_W    = arb_pkg::ADDR_W,
  parameter int DATA_W    = arb_pkg::DATA_W,
  localparam int BW       = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [NUM_LANES-1:0]        req_mask,
  input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
  input  logic [NUM_LANES*DATA_W-1:0] req_wdata,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS*ROW_W-1:0]  bank_row,
  output logic [NUM_LANES-1:0]        grant,
  output logic                        done,
  output logic [NUM_LANES-1:0]        rd_valid,
  output logic [NUM_LANES*DATA_W-1:0] rd_data
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_s1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  logic                        busy_q, busy_d;
  logic                        write_q;
  logic [NUM_LANES-1:0]        pending_q, pending_d;
  logic [NUM_LANES*ADDR_W-1:0] addr_q;
  logic [NUM_LANES*DATA_W-1:0] wdata_q;
  logic [NUM_LANES-1:0]        rd_valid_q, rd_valid_d;
  logic                        accept;

  logic [NUM_LANES-1:0] match_w [NUM_BANKS];
  logic [DATA_W-1:0]    bwdata_w [NUM_BANKS];
  logic [DATA_W-1:0]    brdata_w [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    arb_bank_pick #(
      .NL(NUM_LANES), .NB(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .BANK_IDX(b)
    ) u_pick (
      .pending   (pending_q),
      .lane_addr (addr_q),
      .lane_wdata(wdata_q),
      .en        (bank_en[b]),
      .row       (bank_row[b*ROW_W +: ROW_W]),
      .match     (match_w[b]),
      .wdata     (bwdata_w[b])
    );
    arb_bank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
      .clk  (clk),
      .en   (bank_en[b]),
      .we   (write_q),
      .row  (bank_row[b*ROW_W +: ROW_W]),
      .wdata(bwdata_w[b]),
      .rdata(brdata_w[b])
    );
  end

  // next-state logic
  always_comb begin
    grant = '0;
    for (int b = 0; b < NUM_BANKS; b++) grant = grant | match_w[b];
    done       = busy_q && ((pending_q & ~grant) == '0);
    accept     = req_valid && !busy_q;
    busy_d     = accept ? 1'b1 : (done ? 1'b0 : busy_q);
    pending_d  = accept ? req_mask : (pending_q & ~grant);
    rd_valid_d = write_q ? '0 : grant;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q     <= 1'b0;
      pending_q  <= '0;
      rd_valid_q <= '0;
    end else begin
      busy_q     <= busy_d;
      pending_q  <= pending_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read return: the address registers still hold the lane's bank
  always_comb begin
    rd_valid = rd_valid_q;
    for (int l = 0; l < NUM_LANES; l++) begin
      rd_data[l*DATA_W +: DATA_W] = brdata_w[addr_q[l*ADDR_W +: BW]];
    end
  end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NL = 16,
  parameter int NB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          write,
  input logic [NL-1:0] pending,
  input logic [NL-1:0] grant,
  input logic [NB-1:0] bank_en,
  input logic          done,
  input logic [NL-1:0] rd_valid
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (grant == '0 && bank_en == '0 && !done));

  // R5
  pending_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> pending == ($past(pending) & ~$past(grant)));

  // R4
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pending != '0) |-> grant != '0);

  // R11
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !write) |=> rd_valid == $past(grant));

  // R9
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && write) |=> rd_valid == '0);
endmodule

bind scratch_bank_arb arb_chk #(.NL(NUM_LANES), .NB(NUM_BANKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .busy    (busy_q),
  .write   (write_q),
  .pending (pending_q),
  .grant   (grant),
  .bank_en (bank_en),
  .done    (done),
  .rd_valid(rd_valid)
);

// File: tb/tb_scratch_bank_arb.sv
module tb_scratch_bank_arb;
  localparam int NL = 16, NB = 16, AW = 10, DW = 32, RW = 6;

  logic           clk, rst_n;
  logic           req_valid, req_write;
  logic [NL-1:0]  req_mask;
  logic [NL*AW-1:0] req_addr;
  logic [NL*DW-1:0] req_wdata;
  logic [NB-1:0]  bank_en;
  logic [NB*RW-1:0] bank_row;
  logic [NL-1:0]  grant, rd_valid;
  logic           done;
  logic [NL*DW-1:0] rd_data;

  scratch_bank_arb dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_en(bank_en), .bank_row(bank_row), .grant(grant), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] t_addr [NL];
  logic [DW-1:0] t_data [NL];
  logic [DW-1:0] prev_exp [NL];
  logic [NL-1:0] prev_rv;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_rd(input string req);
    chk(rd_valid == prev_rv, req, "rd_valid", 128'(rd_valid), 128'(prev_rv));
    for (int l = 0; l < NL; l++) begin
      if (prev_rv[l])
        chk(rd_data[l*DW +: DW] === prev_exp[l], req, $sformatf("rd_data lane %0d", l),
            128'(rd_data[l*DW +: DW]), 128'(prev_exp[l]));
    end
  endtask

  task automatic run_req(input string tag, input logic wr, input logic [NL-1:0] mask,
                         input int exp_cycles, input bit poke);
    logic [NL-1:0] sched [$];
    logic [NL-1:0] pend, g, exp_en;
    logic [NB*RW-1:0] exp_row, act_row;
    int first_done, last;
    // behavioural schedule: per bank, lowest pending lane plus same-address lanes
    pend = mask;
    if (mask == '0) sched.push_back('0);
    while (pend != '0) begin
      g = '0;
      for (int b = 0; b < NB; b++) begin
        int lead = -1;
        for (int l = 0; l < NL; l++)
          if (lead < 0 && pend[l] && (t_addr[l] % NB) == b) lead = l;
        if (lead >= 0)
          for (int l = 0; l < NL; l++)
            if (pend[l] && t_addr[l] == t_addr[lead]) g[l] = 1'b1;
      end
      sched.push_back(g);
      pend = pend & ~g;
    end
    last = sched.size() - 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mask = mask;
    for (int l = 0; l < NL; l++) begin
      req_addr[l*AW +: AW]  = t_addr[l];
      req_wdata[l*DW +: DW] = t_data[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    first_done = -1;
    for (int s = 0; s <= last; s++) begin
      if (s > 0) chk_rd("R9");
      if (poke && s == 0 && last > 0) begin
        // R8: a second request while busy must be ignored
        req_valid = 1'b1; req_write = 1'b1; req_mask = '1;
      end
      exp_en = '0; exp_row = '0; act_row = '0;
      for (int l = NL - 1; l >= 0; l--)
        if (sched[s][l]) begin
          exp_en[t_addr[l] % NB] = 1'b1;
          exp_row[(t_addr[l] % NB)*RW +: RW] = RW'(t_addr[l] >> 4);
        end
      for (int b = 0; b < NB; b++)
        if (exp_en[b]) act_row[b*RW +: RW] = bank_row[b*RW +: RW];
      chk(grant == sched[s], "R5", $sformatf("%s grant step %0d", tag, s),
          128'(grant), 128'(sched[s]));
      chk(bank_en == exp_en && act_row == exp_row, "R1", $sformatf("%s banks step %0d", tag, s),
          {bank_en, act_row}, {exp_en, exp_row});
      chk(done == (s == last), "R11", $sformatf("%s done step %0d", tag, s),
          128'(done), 128'(s == last));
      if (done && first_done < 0) first_done = s + 1;
      prev_rv = wr ? '0 : sched[s];
      for (int l = 0; l < NL; l++) begin
        if (sched[s][l]) begin
          if (wr) ref_mem[t_addr[l]] = t_data[l];
          else    prev_exp[l] = ref_mem[t_addr[l]];
        end
      end
      if (s == last) req_valid = 1'b0;
      @(negedge clk);
    end
    chk_rd("R9");
    chk(grant == '0 && !done && bank_en == '0, "R8", {tag, " idle after done"},
        {grant, bank_en, 7'd0, done}, 128'd0);
    if (exp_cycles > 0)
      chk(first_done == exp_cycles, tag, "service cycles", 128'(first_done), 128'(exp_cycles));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_mask = '0; req_addr = '0; req_wdata = '0; prev_rv = '0;
    repeat (3) @(negedge clk);
    chk(grant == '0 && bank_en == '0 && !done && rd_valid == '0, "R10", "in reset",
        {grant, bank_en, rd_valid, done}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(grant == '0 && bank_en == '0 && !done && rd_valid == '0, "R10", "after reset",
        {grant, bank_en, rd_valid, done}, 128'd0);

    // fill words 0..127, one word per bank per request (R2)
    for (int base = 0; base < 128; base += 16) begin
      for (int l = 0; l < NL; l++) begin
        t_addr[l] = AW'(base + l);
        t_data[l] = 32'hA000_0000 | 32'(base << 8) | 32'(l);
      end
      run_req("R2", 1'b1, '1, 1, 1'b0);
    end
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(l);
    run_req("R2", 1'b0, '1, 1, 1'b0);
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(2 * l);
    run_req("R4", 1'b0, '1, 2, 1'b0);
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(8 * l);
    run_req("R4", 1'b0, '1, 8, 1'b1);
    for (int l = 0; l < NL; l++) t_addr[l] = AW'(37);
    run_req("R3", 1'b0, '1, 1, 1'b0);
    for (int l = 0; l < NL; l++) t_addr[l] = AW'((l % 3 == 1) ? 21 : 5);
    run_req("R5", 1'b0, '1, 2, 1'b0);
    for (int l = 0; l < NL; l++) t_addr[l] = AW'((l * 37) % 128);
    run_req("R6", 1'b0, 16'hB5F3, 0, 1'b0);
    run_req("R6", 1'b0, 16'h0000, 1, 1'b0);
    // same-address writes: highest lane wins (R7)
    for (int l = 0; l < NL; l++) begin
      t_addr[l] = AW'(200);
      t_data[l] = 32'h5EED_0000 | 32'(l);
    end
    run_req("R7", 1'b1, '1, 1, 1'b0);
    run_req("R7", 1'b0, '1, 1, 1'b0);
    chk(prev_exp[0] == 32'h5EED_000F, "R7", "stored word", 128'(prev_exp[0]), 128'h5EED_000F);
    for (int l = 0; l < NL; l++) begin
      t_addr[l] = AW'((l < 8) ? 300 : 316);
      t_data[l] = 32'hC0DE_0000 | 32'(l);
    end
    run_req("R7", 1'b1, '1, 2, 1'b0);
    run_req("R7", 1'b0, 16'h8181, 2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule